// File: doc/BRIEF.md
# Two-Wire EEPROM Target Protocol Engine

This block is the byte-level controller of a two-wire serial EEPROM target with a 32,768-byte array, so its word addresses are 15 bits wide. A separate condition detector turns the bus into single-cycle events: start, stop, SCL rising edge and SCL falling edge. It also supplies the sampled SDA level. The engine does four things:

- It shifts whole bytes in from the bus and out to it.
- It drives an SDA pull-down enable for acknowledge bits and for read data.
- It keeps the persistent internal word-address counter.
- It sends read and write requests to the memory side.

The memory side does three things:

- It answers reads one cycle after the request.
- It collects written bytes in a page buffer.
- It starts its self-timed write cycle when `commit_o` pulses. It holds `wr_busy_i` high for the whole of that cycle.

A transfer always begins with a device byte: the 4-bit family code, then the three select bits, then a direction bit. A write transfer sends two address bytes and then any number of data bytes. Each data byte goes to the counter address, and the counter advances inside a 64-byte page. A read transfer streams bytes from the counter and walks the whole array. A random read is a write transfer that stops after the address bytes, followed by a repeated start and a read.

Top module: `eep_target_engine`

## Requirements
- R1: A device byte is acknowledged only when bits 7..4 equal 4'b1010, bits 3..1 equal `dev_sel_i` and `wr_busy_i` is low. Bit 0 selects the direction: 1 means read and 0 means write. To acknowledge, the engine holds `sda_oe_o` high for the whole ninth SCL clock of the byte.
- R2: When the select bits differ from `dev_sel_i`, the engine returns to idle. It does not drive SDA during that byte's ninth clock or during any later byte of the same transfer.
- R3: In a write transfer, the two bytes after the device byte are acknowledged and loaded into the counter. The first byte supplies address bits 14..8, and its bit 7 is ignored. The second byte supplies bits 7..0.
- R4: Each data byte of a write transfer is acknowledged and produces one `mem_wr_o` pulse at the counter address. After each byte, the low 6 counter bits increment and wrap inside the page, and bits 14..6 are unchanged.
- R5: `commit_o` pulses once, the cycle after a stop, but only when that stop follows at least one complete data byte and arrives at a byte boundary. A write transfer that carries no data byte never commits.
- R6: A read transfer first returns the byte at the counter, MSB first. The counter then holds the address of the last byte sent, plus one, and it keeps that value into the next transfer.
- R7: A random read returns the byte at the address loaded by the dummy write that precedes the repeated start.
- R8: Each master acknowledge (SDA low on the ninth clock) makes the engine send the byte at the next address. Address 0x7FFF is followed by address 0x0000.
- R9: After a master not-acknowledge, the engine releases SDA and drives nothing until the next start. After reset, `sda_oe_o`, `mem_rd_o`, `mem_wr_o` and `commit_o` are all low.
- R10: While `wr_busy_i` is high the device byte is not acknowledged. Once `wr_busy_i` falls, the same byte is acknowledged, which makes acknowledge polling possible.
- R11: A stop or start that arrives in the middle of a data byte abandons the transfer. No write cycle is committed, and a random read of the target address afterwards returns the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition event, one cycle |
| stop_i | input | 1 | Stop condition event, one cycle |
| scl_rise_i | input | 1 | SCL rising-edge event |
| scl_fall_i | input | 1 | SCL falling-edge event |
| sda_i | input | 1 | Sampled SDA level |
| dev_sel_i | input | 3 | Hardwired select bits |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| mem_rdata_i | input | 8 | Read data, valid one cycle after `mem_rd_o` |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mem_rd_o | output | 1 | Read request pulse |
| mem_wr_o | output | 1 | Page-buffer write pulse |
| mem_addr_o | output | 15 | Request address |
| mem_wdata_o | output | 8 | Write data |
| commit_o | output | 1 | Start of the internal write cycle |

## Verification
The hardest behaviour to reach is where a stop lands. One SCL rising edge always comes before a stop, and at a byte boundary that edge already shifts one bit in. The engine must treat a stop after that single edge as a boundary, but treat a stop that follows four bits as an abort. The stimulus drives both cases: a complete page write that commits, and a transfer that breaks off in the fifth bit of its second data byte. The commit count, the busy line and a later random read of the target address then show which of the two happened. The tests also poll acknowledges while the bench model of the memory holds the busy line high. They read across the wrap from the last array address to address zero, and they run a page write that wraps inside its page.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/eep_shift.sv
module eep_shift #(
  parameter int W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         load_i,
  input  logic [W-1:0]                 load_data_i,
  input  logic                         rx_en_i,
  input  logic                         tx_en_i,
  input  logic                         sda_i,
  input  logic                         scl_rise_i,
  input  logic                         scl_fall_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(W+1)-1:0]       cnt_o,
  output logic                         fall_seen_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sreg_q;
  logic [CW-1:0] cnt_q;
  logic          fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      sreg_q <= load_data_i;
      cnt_q  <= '0;
    end else if (rx_en_i && scl_rise_i && (cnt_q < CW'(W))) begin
      sreg_q <= {sreg_q[W-2:0], sda_i};
      cnt_q  <= cnt_q + 1'b1;
    end else if (tx_en_i && scl_fall_i) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // tracks whether SCL has fallen since the last rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fall_q <= 1'b0;
    else if (clear_i)     fall_q <= 1'b0;
    else if (scl_rise_i)  fall_q <= 1'b0;
    else if (scl_fall_i)  fall_q <= 1'b1;
  end

  assign data_o      = sreg_q;
  assign cnt_o       = cnt_q;
  assign fall_seen_o = fall_q;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_page_i,
  input  logic          inc_full_i,
  output logic [AW-1:0] ctr_o,
  output logic [AW-1:0] ctr_inc_o
);
  logic [AW-1:0] ctr_q;
  logic [AW-1:0] page_next;

  assign ctr_inc_o = ctr_q + 1'b1;

  generate
    if (PW < AW) begin : g_paged
      assign page_next = {ctr_q[AW-1:PW], ctr_q[PW-1:0] + 1'b1};

      AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_page_i && !load_i) |=> (ctr_q[AW-1:PW] == $past(ctr_q[AW-1:PW]))); // R4
    end else begin : g_flat
      assign page_next = ctr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctr_q <= '0;
    else if (load_i)     ctr_q <= load_val_i;
    else if (inc_page_i) ctr_q <= page_next;
    else if (inc_full_i) ctr_q <= ctr_inc_o;
  end

  assign ctr_o = ctr_q;
endmodule

// File: rtl/eep_dev_match.sv
module eep_dev_match #(
  parameter logic [3:0] CODE = 4'b1010
) (
  input  logic [7:0] byte_i,
  input  logic [2:0] sel_i,
  input  logic       busy_i,
  output logic       hit_o,
  output logic       rd_o
);
  assign hit_o = (byte_i[7:4] == CODE) && (byte_i[3:1] == sel_i) && !busy_i;
  assign rd_o  = byte_i[0];
endmodule

// File: rtl/eep_target_engine.sv
module eep_target_engine
  import eep_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter int         PAGE_W   = 6,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_sel_i,
  input  logic              wr_busy_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_oe_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              commit_o
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int AHI_W  = ADDR_W - BYTE_W;

  state_e              state_q;
  rx_kind_e            kind_q;
  logic                read_q;
  logic                wrote_q;
  logic                mack_q;
  logic                rd_pend_q;
  logic [BYTE_W-1:0]   hold_q;
  logic [AHI_W-1:0]    ahi_q;

  logic [BYTE_W-1:0]   sh_byte;
  logic [CNT_W-1:0]    sh_cnt;
  logic                sh_fall_seen;
  logic                sh_clear, sh_load;
  logic                ev_ok, rx_done, tx_end, at_boundary;
  logic                dev_hit, dev_rd;
  logic [ADDR_W-1:0]   ctr, ctr_inc;

  assign ev_ok       = !start_i && !stop_i;
  assign rx_done     = ev_ok && (state_q == ST_RX) && scl_fall_i && (sh_cnt == CNT_W'(BYTE_W));
  assign tx_end      = ev_ok && (state_q == ST_TX) && scl_fall_i && (sh_cnt == CNT_W'(BYTE_W - 1));
  // a stop right after the first SCL rise of a byte is still on the boundary
  assign at_boundary = (sh_cnt == '0) || ((sh_cnt == CNT_W'(1)) && !sh_fall_seen);

  assign sh_clear = start_i || stop_i ||
                    ((state_q == ST_ACK) && scl_fall_i && !read_q);
  assign sh_load  = ev_ok && scl_fall_i &&
                    (((state_q == ST_ACK) && read_q) || ((state_q == ST_MACK) && mack_q));

  eep_shift #(.W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (sh_clear),
    .load_i      (sh_load),
    .load_data_i (hold_q),
    .rx_en_i     (state_q == ST_RX),
    .tx_en_i     (state_q == ST_TX),
    .sda_i       (sda_i),
    .scl_rise_i  (scl_rise_i),
    .scl_fall_i  (scl_fall_i),
    .data_o      (sh_byte),
    .cnt_o       (sh_cnt),
    .fall_seen_o (sh_fall_seen)
  );

  eep_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rx_done && (kind_q == RX_ALO)),
    .load_val_i ({ahi_q, sh_byte}),
    .inc_page_i (rx_done && (kind_q == RX_DATA)),
    .inc_full_i (tx_end),
    .ctr_o      (ctr),
    .ctr_inc_o  (ctr_inc)
  );

  eep_dev_match #(.CODE(DEV_CODE)) u_match (
    .byte_i (sh_byte),
    .sel_i  (dev_sel_i),
    .busy_i (wr_busy_i),
    .hit_o  (dev_hit),
    .rd_o   (dev_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= RX_DEV;
      read_q      <= 1'b0;
      wrote_q     <= 1'b0;
      mack_q      <= 1'b0;
      rd_pend_q   <= 1'b0;
      hold_q      <= '0;
      ahi_q       <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      commit_o    <= 1'b0;
    end else begin
      mem_rd_o  <= 1'b0;
      mem_wr_o  <= 1'b0;
      commit_o  <= 1'b0;
      rd_pend_q <= mem_rd_o;
      if (rd_pend_q) hold_q <= mem_rdata_i;

      if (start_i) begin
        state_q <= ST_RX;
        kind_q  <= RX_DEV;
        read_q  <= 1'b0;
        wrote_q <= 1'b0;
      end else if (stop_i) begin
        if ((state_q == ST_RX) && (kind_q == RX_DATA) && wrote_q && at_boundary)
          commit_o <= 1'b1;
        state_q <= ST_IDLE;
        wrote_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (rx_done) begin
              unique case (kind_q)
                RX_DEV: begin
                  if (dev_hit) begin
                    state_q <= ST_ACK;
                    read_q  <= dev_rd;
                    kind_q  <= RX_AHI;
                    if (dev_rd) begin
                      mem_rd_o   <= 1'b1;
                      mem_addr_o <= ctr;
                    end
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                RX_AHI: begin
                  ahi_q   <= sh_byte[AHI_W-1:0];
                  kind_q  <= RX_ALO;
                  state_q <= ST_ACK;
                end
                RX_ALO: begin
                  kind_q  <= RX_DATA;
                  state_q <= ST_ACK;
                end
                RX_DATA: begin
                  mem_wr_o    <= 1'b1;
                  mem_addr_o  <= ctr;
                  mem_wdata_o <= sh_byte;
                  wrote_q     <= 1'b1;
                  state_q     <= ST_ACK;
                end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) state_q <= read_q ? ST_TX : ST_RX;
          end
          ST_TX: begin
            if (tx_end) begin
              state_q    <= ST_MACK;
              mem_rd_o   <= 1'b1;
              mem_addr_o <= ctr_inc;
            end
          end
          ST_MACK: begin
            if (scl_rise_i) mack_q <= !sda_i;
            if (scl_fall_i) state_q <= mack_q ? ST_TX : ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = (state_q == ST_ACK) || ((state_q == ST_TX) && !sh_byte[BYTE_W-1]);

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && (kind_q == RX_DEV) && wr_busy_i) |=> !sda_oe_o); // R10

  AST_MISMATCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && (kind_q == RX_DEV) && (sh_byte[3:1] != dev_sel_i)) |=>
      ((state_q == ST_IDLE) && !sda_oe_o)); // R2

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R6

  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_i)); // R5

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R11

  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_MACK) && scl_fall_i && !mack_q && ev_ok) |=> !sda_oe_o); // R9
endmodule

// File: tb/eep_target_engine_tb.sv
module eep_target_engine_tb;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, stop_i = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic          sda_m = 1'b1;
  logic          sda_line;
  logic          wr_busy;
  logic [7:0]    mem_rdata = '0;
  logic          sda_oe_o, mem_rd_o, mem_wr_o, commit_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;

  eep_target_engine u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_i       (sda_line),
    .dev_sel_i   (3'b101),
    .wr_busy_i   (wr_busy),
    .mem_rdata_i (mem_rdata),
    .sda_oe_o    (sda_oe_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .commit_o    (commit_o)
  );

  int n_chk = 0, n_fail = 0, n_commit = 0, busy_cnt = 0;
  logic oe_seen = 1'b0;
  logic [7:0] ref_mem [int];
  logic [7:0] arr_mem [int];
  logic [7:0] pend    [int];
  int   exp_q [$];
  int   act_q [$];
  string tag_q [$];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : pat(a);
  endfunction

  assign wr_busy = (busy_cnt != 0);

  // memory-side model: one-cycle read, page buffer, timed busy after commit
  always @(posedge clk) begin
    if (mem_rd_o)
      mem_rdata <= arr_mem.exists(int'(mem_addr_o)) ? arr_mem[int'(mem_addr_o)] : pat(int'(mem_addr_o));
    if (mem_wr_o) pend[int'(mem_addr_o)] = mem_wdata_o;
    if (start_i) pend.delete();
    if (commit_o) begin
      foreach (pend[k]) arr_mem[k] = pend[k];
      pend.delete();
      n_commit++;
      busy_cnt <= 300;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
    if (sda_oe_o) oe_seen = 1'b1;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0)
        check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic expect_byte(string tag, int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  task automatic bit_clk(input logic b, output logic s);
    @(negedge clk) sda_m = b;
    repeat (3) @(negedge clk);
    scl_rise = 1'b1;
    @(negedge clk) scl_rise = 1'b0;
    repeat (3) @(negedge clk);
    s = sda_line;
    scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) sda_m = 1'b1;
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk) sda_m = 1'b0;
    repeat (2) @(negedge clk);
    scl_rise = 1'b1;
    @(negedge clk) scl_rise = 1'b0;
    repeat (2) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    sda_m = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_chk(string tag, logic [7:0] b, logic exp_nack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    check(tag, s, exp_nack);
  endtask

  task automatic recv(logic m_ack);
    logic s;
    logic [7:0] d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_clk(1'b1, s);
      d = {d[6:0], s};
    end
    bit_clk(!m_ack, s);
    act_q.push_back(int'(d));
  endtask

  localparam logic [7:0] DEV_W = 8'b1010_1010;
  localparam logic [7:0] DEV_R = 8'b1010_1011;

  task automatic set_addr(string tag, int a);
    do_start();
    send_chk(tag, DEV_W, 1'b0);
    send_chk(tag, {1'b1, 7'(a >> 8)}, 1'b0);  // bit 7 is don't-care
    send_chk(tag, 8'(a), 1'b0);
  endtask

  task automatic read_run(string tag, int a, int n);
    for (int k = 0; k < n; k++) expect_byte(tag, ref_rd((a + k) & 32'h7FFF));
    do_start();
    send_chk(tag, DEV_R, 1'b0);
    for (int k = 0; k < n; k++) recv(k < n - 1);
  endtask

  task automatic wait_idle();
    while (wr_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset oe", sda_oe_o, 0);
    check("R9 reset rd", mem_rd_o, 0);
    check("R9 reset wr", mem_wr_o, 0);
    check("R9 reset commit", commit_o, 0);

    // R2: select mismatch stays silent
    oe_seen = 1'b0;
    do_start();
    send_chk("R2 mismatch nack", 8'b1010_0110, 1'b1);
    send_chk("R2 later byte", 8'h55, 1'b1);
    do_stop();
    check("R2 no drive", oe_seen, 0);

    // R1: wrong family code
    do_start();
    send_chk("R1 family code", 8'b1011_1010, 1'b1);
    do_stop();

    // R1 R3 R4 R5: byte write at 0x0123, then acknowledge polling
    set_addr("R3 address load", 'h0123);
    send_chk("R4 data ack", 8'h5A, 1'b0);
    ref_mem['h0123] = 8'h5A;
    do_stop();
    check("R5 commit after byte write", n_commit, 1);
    do_start();
    send_chk("R10 busy nack", DEV_W, 1'b1);
    do_stop();
    wait_idle();
    do_start();
    send_chk("R10 ack after busy", DEV_W, 1'b0);
    do_stop();
    check("R5 no commit without data", n_commit, 1);

    // R7: random read, R9: release after master nack
    set_addr("R7 dummy write", 'h0123);
    read_run("R7 random read", 'h0123, 1);
    @(negedge clk);
    check("R9 released after nack", sda_oe_o, 0);
    do_stop();

    // R6: current-address read
    read_run("R6 current read", 'h0124, 1);
    do_stop();

    // R4: page write wraps inside the page
    set_addr("R4 page addr", 'h013E);
    send_chk("R4 page d0", 8'h11, 1'b0);
    send_chk("R4 page d1", 8'h22, 1'b0);
    send_chk("R4 page d2", 8'h33, 1'b0);
    ref_mem['h013E] = 8'h11;
    ref_mem['h013F] = 8'h22;
    ref_mem['h0100] = 8'h33;
    do_stop();
    check("R5 commit after page write", n_commit, 2);
    wait_idle();
    read_run("R4 counter after wrap", 'h0101, 1);
    do_stop();
    set_addr("R8 seq addr", 'h013E);
    read_run("R8 sequential", 'h013E, 4);
    do_stop();
    set_addr("R4 wrap addr", 'h0100);
    read_run("R4 wrapped byte", 'h0100, 1);
    do_stop();

    // R8: sequential read across the top of the array
    set_addr("R8 wrap addr", 'h7FFE);
    read_run("R8 array wrap", 'h7FFE, 3);
    do_stop();
    read_run("R8 counter after wrap", 'h0001, 1);
    do_stop();

    // R11: stop in the middle of a data byte
    set_addr("R11 addr", 'h0200);
    send_chk("R11 first data", 8'hAA, 1'b0);
    for (int i = 0; i < 4; i++) bit_clk(1'b1, s);
    do_stop();
    repeat (4) @(negedge clk);
    check("R11 no commit on abort", n_commit, 2);
    check("R11 not busy", wr_busy, 0);
    set_addr("R11 readback addr", 'h0200);
    read_run("R11 old content", 'h0200, 1);
    do_stop();

    // R11: start in the middle of a data byte, then current read
    set_addr("R11 addr2", 'h0210);
    for (int i = 0; i < 3; i++) bit_clk(1'b0, s);
    read_run("R11 start abort", 'h0210, 1);
    do_stop();
    check("R11 no commit on start abort", n_commit, 2);

    repeat (10) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule